// File: doc/BRIEF.md
# Data Memory Access Router

This block sits between the memory request port of an 8051-class processor core and four storage targets: a 256-byte on-chip scratch RAM, the special function register (SFR) bus, a 768-byte on-chip expanded RAM, and the external memory bus interface. For each request it looks at the address, the addressing mode, and a control bit that enables the on-chip expanded RAM. From these it picks exactly one target, drives that target's strobes, and returns the read data one cycle later.

Two rules make the block more than an address decoder. The upper half of the 8-bit internal space (80h–FFh) reaches either the SFR bus or the scratch RAM, and only the addressing mode decides which. MOVX accesses are kept on chip while the enable bit is clear and the address is below the expanded RAM size. In that case the external bus signals stay completely idle.

Modes on `reqMode`: 0 = direct, 1 = register-indirect, 2 = MOVX with a 16-bit pointer (DPTR), 3 = MOVX with an 8-bit register pointer (Ri).

Top module: `mem_router`

## Requirements
- R1: Direct (mode 0) and indirect (mode 1) requests to 00h–7Fh read and write the scratch RAM at `reqAddr[7:0]`. Both modes reach the same storage.
- R2: A direct request to 80h–FFh selects the SFR bus. It drives `sfrAddr` = `reqAddr[7:0]`, pulses `sfrWe` or `sfrRe`, and on a write drives `sfrWdata`. An indirect request to the same address uses scratch RAM, and SFR reads never change the scratch RAM. When the SFR bus is not selected, `sfrAddr`, `sfrWe`, `sfrRe` and `sfrWdata` are 0.
- R3: With the enable bit 0, a mode 2 request with `reqAddr` 0000h–02FFh uses the expanded RAM at that address, and 0300h upward goes to the external bus. Expanded RAM storage is distinct from scratch RAM.
- R4: With the enable bit 1, every mode 2 and mode 3 request goes to the external bus.
- R5: While the expanded RAM is selected, `extReq`, `extWrite`, `extAddr`, `extWdata` and `extShortAddr` are all 0. The same holds for every request that does not select the external bus.
- R6: A mode 3 request with the enable bit 0 forms the 10-bit expanded RAM address as {`pageSel`, `reqAddr[7:0]`}. A page value of 3 falls outside the window and goes to the external bus.
- R7: An external request drives `extReq` = 1, `extWrite` = direction, and `extWdata` = write data on writes (0 on reads). For mode 2 it drives `extAddr` = `reqAddr` and `extShortAddr` = 0. For mode 3 it drives `extAddr` = {`extHiPort`, `reqAddr[7:0]`} and `extShortAddr` = 1.
- R8: Exactly one of `selScratch`, `selSfr`, `selXram`, `selExt` is 1 while `reqValid` is 1, and none is 1 otherwise.
- R9: A read request sets `rdValid` to 1 in the next cycle, with `rdData` holding the selected target's byte. In every other cycle `rdValid` is 0.
- R10: The expanded RAM enable bit resets to 0, which means expanded RAM is enabled. `auxWe` loads it from `auxExtram`, and the new value governs requests from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqMode | input | 2 | Addressing mode (0 direct, 1 indirect, 2 MOVX DPTR, 3 MOVX Ri) |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 16 | Request address (modes 0, 1, 3 use bits 7:0) |
| reqWdata | input | 8 | Write data |
| pageSel | input | 2 | Expanded RAM page for mode 3 |
| extHiPort | input | 8 | High address byte latch for mode 3 external accesses |
| auxWe | input | 1 | Load the expanded RAM enable bit |
| auxExtram | input | 1 | New enable bit value (1 = all MOVX external) |
| selScratch | output | 1 | Scratch RAM selected |
| selSfr | output | 1 | SFR bus selected |
| selXram | output | 1 | Expanded RAM selected |
| selExt | output | 1 | External bus selected |
| sfrAddr | output | 8 | SFR address |
| sfrWe | output | 1 | SFR write strobe |
| sfrRe | output | 1 | SFR read strobe |
| sfrWdata | output | 8 | SFR write data |
| sfrRdata | input | 8 | SFR read data (same cycle) |
| extReq | output | 1 | External bus access request |
| extWrite | output | 1 | External write |
| extAddr | output | 16 | External address |
| extWdata | output | 8 | External write data |
| extShortAddr | output | 1 | Address came from an 8-bit pointer |
| extRdata | input | 8 | External read data (same cycle) |
| rdData | output | 8 | Read data, one cycle after the request |
| rdValid | output | 1 | rdData valid |

## Verification
The hardest state to reach from the ports is one where the scratch RAM and the expanded RAM hold different bytes at the same low address, while the enable bit has just changed. A read then shows whether the byte came from the right array, and whether the routing picked up the new bit at the correct cycle. The stimulus writes distinct values at A0h through indirect mode and through MOVX. It then toggles the enable bit in the cycle before a MOVX to the same address, and reads everything back while a behavioural model tracks both arrays, the bit, and the pending read data on every clock. Boundary addresses 02FFh/0300h and Ri page 3 are applied the same way.

// File: rtl/mem_router_pkg.sv
package mem_router_pkg;

  typedef enum logic [1:0] {
    MODE_DIRECT    = 2'd0,
    MODE_INDIRECT  = 2'd1,
    MODE_MOVX_DPTR = 2'd2,
    MODE_MOVX_RI   = 2'd3
  } accMode_t;

  typedef enum logic [1:0] {
    TGT_SCRATCH = 2'd0,
    TGT_SFR     = 2'd1,
    TGT_XRAM    = 2'd2,
    TGT_EXT     = 2'd3
  } target_t;

  // control -> datapath strobes
  typedef struct packed {
    logic scratch;
    logic sfr;
    logic xram;
    logic ext;
    logic wr;
    logic rd;
    logic shortAddr;
  } strobe_t;

endpackage

// File: rtl/mem_router_spram.sv
module mem_router_spram #(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdataQ;

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdataQ    <= mem[addr];
    end
  end

  assign rdata = rdataQ;

endmodule

// File: rtl/mem_router_ctrl.sv
module mem_router_ctrl
  import mem_router_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int XRAM_DEPTH = 768,
  parameter int SFR_BASE   = 128,
  parameter int PAGE_W     = $clog2(XRAM_DEPTH) - 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqMode,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [PAGE_W-1:0] pageSel,
  input  logic              auxWe,
  input  logic              auxExtram,
  output strobe_t           strobe
);

  localparam int XRAM_AW = $clog2(XRAM_DEPTH);
  localparam logic [ADDR_W-1:0]  DPTR_LIMIT = ADDR_W'(XRAM_DEPTH);
  localparam logic [XRAM_AW-1:0] RI_LIMIT   = XRAM_AW'(XRAM_DEPTH);
  localparam logic [7:0]         SFR_LO     = 8'(SFR_BASE);

  accMode_t mode;
  logic extramQ;
  logic dptrInWindow, riInWindow, upperHalf, isMovx;

  assign mode = accMode_t'(reqMode);

  // expanded RAM enable bit; 0 after reset keeps MOVX on chip
  always_ff @(posedge clk) begin
    if (!rstN)      extramQ <= 1'b0;
    else if (auxWe) extramQ <= auxExtram;
  end

  assign dptrInWindow = reqAddr < DPTR_LIMIT;
  assign riInWindow   = {pageSel, reqAddr[7:0]} < RI_LIMIT;
  assign upperHalf    = reqAddr[7:0] >= SFR_LO;
  assign isMovx       = (mode == MODE_MOVX_DPTR) || (mode == MODE_MOVX_RI);

  target_t tgt;
  always_comb begin
    unique case (mode)
      MODE_DIRECT:    tgt = upperHalf ? TGT_SFR : TGT_SCRATCH;
      MODE_INDIRECT:  tgt = TGT_SCRATCH;
      MODE_MOVX_DPTR: tgt = (!extramQ && dptrInWindow) ? TGT_XRAM : TGT_EXT;
      default:        tgt = (!extramQ && riInWindow)   ? TGT_XRAM : TGT_EXT;
    endcase
  end

  always_comb begin
    strobe           = '0;
    strobe.scratch   = reqValid && (tgt == TGT_SCRATCH);
    strobe.sfr       = reqValid && (tgt == TGT_SFR);
    strobe.xram      = reqValid && (tgt == TGT_XRAM);
    strobe.ext       = reqValid && (tgt == TGT_EXT);
    strobe.wr        = reqValid && reqWrite;
    strobe.rd        = reqValid && !reqWrite;
    strobe.shortAddr = (mode == MODE_MOVX_RI);
  end

  assert_one_target_R8: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> $countones({strobe.scratch, strobe.sfr, strobe.xram, strobe.ext}) == 1);

  assert_idle_no_target_R8: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> !(strobe.scratch || strobe.sfr || strobe.xram || strobe.ext));

  assert_indirect_to_scratch_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && mode == MODE_INDIRECT) |-> strobe.scratch);

  assert_movx_off_chip_R4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && isMovx && extramQ) |-> strobe.ext);

  assert_movx_never_internal_R3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && isMovx) |-> !(strobe.scratch || strobe.sfr));

endmodule

// File: rtl/mem_router_dp.sv
module mem_router_dp
  import mem_router_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 8,
  parameter int SCRATCH_DEPTH = 256,
  parameter int XRAM_DEPTH    = 768,
  parameter int PAGE_W        = $clog2(XRAM_DEPTH) - 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [PAGE_W-1:0] pageSel,
  input  logic [ADDR_W-9:0] extHiPort,
  output logic [7:0]        sfrAddr,
  output logic              sfrWe,
  output logic              sfrRe,
  output logic [DATA_W-1:0] sfrWdata,
  input  logic [DATA_W-1:0] sfrRdata,
  output logic              extReq,
  output logic              extWrite,
  output logic [ADDR_W-1:0] extAddr,
  output logic [DATA_W-1:0] extWdata,
  output logic              extShortAddr,
  input  logic [DATA_W-1:0] extRdata,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  localparam int SCR_AW  = $clog2(SCRATCH_DEPTH);
  localparam int XRAM_AW = $clog2(XRAM_DEPTH);

  logic [XRAM_AW-1:0] xramAddr;
  logic [DATA_W-1:0]  scratchRd, xramRd, sfrQ, extQ;
  target_t            tgtQ;
  logic               rdValidQ;

  assign xramAddr = strobe.shortAddr ? {pageSel, reqAddr[7:0]} : reqAddr[XRAM_AW-1:0];

  mem_router_spram #(.DEPTH(SCRATCH_DEPTH), .DATA_W(DATA_W)) scratch_i (
    .clk(clk), .en(strobe.scratch), .we(strobe.wr),
    .addr(reqAddr[SCR_AW-1:0]), .wdata(reqWdata), .rdata(scratchRd));

  mem_router_spram #(.DEPTH(XRAM_DEPTH), .DATA_W(DATA_W)) xram_i (
    .clk(clk), .en(strobe.xram), .we(strobe.wr),
    .addr(xramAddr), .wdata(reqWdata), .rdata(xramRd));

  // SFR bus: idle unless selected
  assign sfrAddr  = strobe.sfr ? reqAddr[7:0] : '0;
  assign sfrWe    = strobe.sfr && strobe.wr;
  assign sfrRe    = strobe.sfr && strobe.rd;
  assign sfrWdata = (strobe.sfr && strobe.wr) ? reqWdata : '0;

  // external bus: idle unless selected
  assign extReq       = strobe.ext;
  assign extWrite     = strobe.ext && strobe.wr;
  assign extShortAddr = strobe.ext && strobe.shortAddr;
  assign extWdata     = (strobe.ext && strobe.wr) ? reqWdata : '0;
  always_comb begin
    if (!strobe.ext)          extAddr = '0;
    else if (strobe.shortAddr) extAddr = {extHiPort, reqAddr[7:0]};
    else                      extAddr = reqAddr;
  end

  // read return, one cycle latency
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValidQ <= 1'b0;
      tgtQ     <= TGT_SCRATCH;
    end else begin
      rdValidQ <= strobe.rd;
      if (strobe.rd) begin
        if (strobe.sfr)       tgtQ <= TGT_SFR;
        else if (strobe.xram) tgtQ <= TGT_XRAM;
        else if (strobe.ext)  tgtQ <= TGT_EXT;
        else                  tgtQ <= TGT_SCRATCH;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.rd && strobe.sfr) sfrQ <= sfrRdata;
    if (strobe.rd && strobe.ext) extQ <= extRdata;
  end

  always_comb begin
    rdData = '0;
    if (rdValidQ) begin
      unique case (tgtQ)
        TGT_SCRATCH: rdData = scratchRd;
        TGT_SFR:     rdData = sfrQ;
        TGT_XRAM:    rdData = xramRd;
        default:     rdData = extQ;
      endcase
    end
  end

  assign rdValid = rdValidQ;

  assert_xram_bus_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.xram |-> (!extReq && !extWrite && extAddr == '0 && extWdata == '0 && !extShortAddr));

  assert_read_returns_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rd |=> rdValid);

  assert_no_spurious_valid_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rd |=> !rdValid);

  assert_sfr_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.sfr |-> (!sfrWe && !sfrRe && sfrAddr == '0));

endmodule

// File: rtl/mem_router.sv
module mem_router
  import mem_router_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 8,
  parameter int SCRATCH_DEPTH = 256,
  parameter int XRAM_DEPTH    = 768,
  parameter int SFR_BASE      = 128,
  parameter int PAGE_W        = $clog2(XRAM_DEPTH) - 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqMode,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [PAGE_W-1:0] pageSel,
  input  logic [ADDR_W-9:0] extHiPort,
  input  logic              auxWe,
  input  logic              auxExtram,
  output logic              selScratch,
  output logic              selSfr,
  output logic              selXram,
  output logic              selExt,
  output logic [7:0]        sfrAddr,
  output logic              sfrWe,
  output logic              sfrRe,
  output logic [DATA_W-1:0] sfrWdata,
  input  logic [DATA_W-1:0] sfrRdata,
  output logic              extReq,
  output logic              extWrite,
  output logic [ADDR_W-1:0] extAddr,
  output logic [DATA_W-1:0] extWdata,
  output logic              extShortAddr,
  input  logic [DATA_W-1:0] extRdata,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  strobe_t strobe;

  mem_router_ctrl #(
    .ADDR_W(ADDR_W), .XRAM_DEPTH(XRAM_DEPTH), .SFR_BASE(SFR_BASE), .PAGE_W(PAGE_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqMode(reqMode),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .pageSel(pageSel),
    .auxWe(auxWe), .auxExtram(auxExtram), .strobe(strobe));

  mem_router_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SCRATCH_DEPTH(SCRATCH_DEPTH),
    .XRAM_DEPTH(XRAM_DEPTH), .PAGE_W(PAGE_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .pageSel(pageSel), .extHiPort(extHiPort),
    .sfrAddr(sfrAddr), .sfrWe(sfrWe), .sfrRe(sfrRe), .sfrWdata(sfrWdata),
    .sfrRdata(sfrRdata), .extReq(extReq), .extWrite(extWrite),
    .extAddr(extAddr), .extWdata(extWdata), .extShortAddr(extShortAddr),
    .extRdata(extRdata), .rdData(rdData), .rdValid(rdValid));

  assign selScratch = strobe.scratch;
  assign selSfr     = strobe.sfr;
  assign selXram    = strobe.xram;
  assign selExt     = strobe.ext;

endmodule

// File: tb/mem_router_tb_top.sv
module mem_router_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 0, reqWrite = 0, auxWe = 0, auxExtram = 0;
  logic [1:0] reqMode = 0, pageSel = 0;
  logic [15:0] reqAddr = 0;
  logic [7:0] reqWdata = 0, extHiPort = 0;
  logic selScratch, selSfr, selXram, selExt, sfrWe, sfrRe, extReq, extWrite, extShortAddr, rdValid;
  logic [7:0] sfrAddr, sfrWdata, sfrRdata, extWdata, extRdata, rdData;
  logic [15:0] extAddr;

  always #2 clk = ~clk;

  // target responders
  assign sfrRdata = sfrAddr ^ 8'hA5;
  assign extRdata = extAddr[7:0] ^ extAddr[15:8] ^ 8'h3C;

  mem_router dut_i (.*);

  int vectors = 0, fails = 0;
  logic [7:0] mScr [256];
  logic [7:0] mXr [768];
  bit mExtram = 0;
  bit pendV = 0;
  logic [7:0] pendD = 0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, bit valid, int mode, bit wr, int addr, int wd,
                      int page = 0, int hi = 0, bit aWe = 0, bit aVal = 0);
    bit eScr, eSfr, eXr, eExt;
    int xa, ea;
    @(negedge clk);
    reqValid = valid; reqMode = 2'(mode); reqWrite = wr; reqAddr = 16'(addr);
    reqWdata = 8'(wd); pageSel = 2'(page); extHiPort = 8'(hi);
    auxWe = aWe; auxExtram = aVal;
    #1;
    vectors++;
    eScr = 0; eSfr = 0; eXr = 0; eExt = 0;
    xa = (mode == 3) ? page * 256 + (addr & 255) : addr;
    if (valid) begin
      if (mode == 0) begin if ((addr & 255) >= 128) eSfr = 1; else eScr = 1; end
      else if (mode == 1) eScr = 1;
      else if (!mExtram && xa < 768) eXr = 1;
      else eExt = 1;
    end
    ea = eExt ? ((mode == 3) ? hi * 256 + (addr & 255) : addr) : 0;
    chk(tag, "selScratch", selScratch, eScr);
    chk(tag, "selSfr", selSfr, eSfr);
    chk(tag, "selXram", selXram, eXr);
    chk(tag, "selExt", selExt, eExt);
    chk(tag, "sfrAddr", sfrAddr, eSfr ? (addr & 255) : 0);
    chk(tag, "sfrWe", sfrWe, eSfr && wr);
    chk(tag, "sfrRe", sfrRe, eSfr && !wr);
    chk(tag, "sfrWdata", sfrWdata, (eSfr && wr) ? (wd & 255) : 0);
    chk(tag, "extReq", extReq, eExt);
    chk(tag, "extWrite", extWrite, eExt && wr);
    chk(tag, "extAddr", extAddr, ea);
    chk(tag, "extWdata", extWdata, (eExt && wr) ? (wd & 255) : 0);
    chk(tag, "extShortAddr", extShortAddr, eExt && mode == 3);
    chk("R9", "rdValid", rdValid, pendV);
    if (pendV) chk("R9", "rdData", rdData, pendD);
    pendV = valid && !wr;
    if (pendV) begin
      if (eScr) pendD = mScr[addr & 255];
      else if (eSfr) pendD = 8'(addr) ^ 8'hA5;
      else if (eXr) pendD = mXr[xa];
      else pendD = 8'(ea) ^ 8'(ea >> 8) ^ 8'h3C;
    end
    if (valid && wr) begin
      if (eScr) mScr[addr & 255] = 8'(wd);
      if (eXr) mXr[xa] = 8'(wd);
    end
    if (aWe) mExtram = aVal;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog expired: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    // reset state: no target, no read valid
    step("R8", 0, 0, 0, 0, 0);
    // R10: enable bit is 0 after reset, so MOVX low goes on chip
    step("R10", 1, 2, 1, 16'h0100, 8'h42);
    step("R10", 1, 2, 0, 16'h0100, 0);
    // R1 low half, both modes, same storage
    step("R1", 1, 0, 1, 8'h10, 8'h11);
    step("R1", 1, 1, 0, 8'h10, 0);
    step("R1", 1, 1, 1, 8'h7F, 8'hE7);
    step("R1", 1, 0, 0, 8'h7F, 0);
    // R2 upper half by mode
    step("R2", 1, 1, 1, 8'h90, 8'h77);
    step("R2", 1, 0, 1, 8'h90, 8'h12);
    step("R2", 1, 1, 0, 8'h90, 0);
    step("R2", 1, 0, 0, 8'h90, 0);
    step("R2", 1, 0, 0, 8'hFF, 0);
    step("R2", 1, 1, 0, 8'h90, 0);
    // R3 no aliasing at A0h, window edges
    step("R3", 1, 1, 1, 8'hA0, 8'h5A);
    step("R3", 1, 2, 1, 16'h00A0, 8'hC3);
    step("R3", 1, 1, 0, 8'hA0, 0);
    step("R3", 1, 2, 0, 16'h00A0, 0);
    step("R3", 1, 2, 1, 16'h02FF, 8'h9D);
    step("R3", 1, 2, 0, 16'h02FF, 0);
    step("R7", 1, 2, 1, 16'h0300, 8'h61);
    step("R7", 1, 2, 0, 16'hFFFF, 0);
    // R6 Ri paging
    step("R6", 1, 3, 1, 8'h34, 8'hB1, 2, 8'h55);
    step("R6", 1, 2, 0, 16'h0234, 0);
    step("R6", 1, 3, 0, 8'hFF, 0, 1, 8'h00);
    step("R6", 1, 3, 1, 8'h34, 8'h2E, 3, 8'h81);
    step("R7", 1, 3, 0, 8'h34, 0, 3, 8'hC0);
    // R4 enable bit set: all MOVX external; R10 takes effect next cycle
    step("R10", 1, 2, 0, 16'h00A0, 0, 0, 0, 1, 1);
    step("R4", 1, 2, 0, 16'h00A0, 0);
    step("R4", 1, 2, 1, 16'h0010, 8'h3F);
    step("R4", 1, 3, 0, 8'h20, 0, 0, 8'h12);
    step("R4", 1, 1, 0, 8'hA0, 0);
    // clear again, expanded RAM kept its contents
    step("R10", 1, 2, 0, 16'h02FF, 0, 0, 0, 1, 0);
    step("R5", 1, 2, 0, 16'h00A0, 0);
    step("R5", 1, 3, 0, 8'h34, 0, 2, 8'hFF);
    // sweep
    for (int i = 0; i < 120; i++) begin
      step("R3", 1, 2, 1, (i * 37) % 768, (i * 11) & 255);
      step("R1", 1, 1, 1, (i * 13) & 255, (i * 7 + 1) & 255);
      step("R3", 1, 2, 0, (i * 37) % 768, 0);
      step("R1", 1, (((i * 13) & 255) < 128) ? 0 : 1, 0, (i * 13) & 255, 0);
      step("R8", 0, i & 3, 0, i, 0);
    end
    step("R9", 0, 0, 0, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule